// File: doc/BRIEF.md
# Destination Operand Address Generator

This block turns the destination specifier of a 16-bit minicomputer instruction into an effective address. The specifier is a 3-bit addressing mode and a 3-bit register index. The block reads and updates the general register file as each mode requires: post-increment, pre-decrement, or advancing the program counter past an index word. It also fetches pointer and index words over a simple read bus and stalls while that bus is not ready.

The caller raises `start` for one cycle with the mode, the register index and the byte/word size. When `done` pulses, the result is on the `ea_*` outputs. A register-direct destination is reported through `ea_is_reg` and `ea_reg`. A memory destination is reported through `ea_addr`. The result stays on these outputs until the next operation completes.

The block also compares every resolved memory destination against the memory-mapped address of the processor status word (octal 177776, 16'hFFFE). On a match it raises `flag_suppress`, which tells the caller that the result write must not be followed by a condition-code update.

Top module: `dst_ea_gen`

## Requirements
- R1: Mode 0 (register direct) reports `ea_is_reg`=1 with `ea_reg` equal to the register index and `ea_addr`=0. It makes no bus read and leaves the register unchanged.
- R2: Mode 1 (register deferred) gives `ea_addr` equal to the register contents and leaves the register unchanged.
- R3: Mode 2 (auto-increment) gives `ea_addr` equal to the register's old contents. The register then grows by 2 for a word operation (`byte_op`=0) or when the index is 6 or 7, and by 1 otherwise.
- R4: Mode 3 (auto-increment deferred) reads the word at the register's old contents and uses it as `ea_addr`. The register grows by 2 whatever the size.
- R5: Mode 4 (auto-decrement) shrinks the register by 2 for a word operation or when the index is 6 or 7, and by 1 otherwise. `ea_addr` is the new value.
- R6: Mode 5 (auto-decrement deferred) shrinks the register by 2, reads the word at the new value, and uses that word as `ea_addr`.
- R7: Mode 6 (indexed) reads an index word at the address held in register 7 and adds 2 to register 7. `ea_addr` is the selected register's value plus the index, modulo 2^16. When the register is 7, its already-advanced value is used.
- R8: Mode 7 (indexed deferred) forms the same sum as mode 6, reads the word at that sum, and uses the word as `ea_addr`.
- R9: `flag_suppress` is 1 exactly when the result is a memory destination equal to 16'hFFFE. It is always 0 for register-direct results, including a register that holds 16'hFFFE.
- R10: `done` is a one-cycle pulse. Counted in clock edges from the edge that samples `start` to the edge that raises `done`, the latency is 2 for modes 0, 1, 2 and 4. It is 3+L for modes 3 and 5, 4+L for mode 6, and 5+2L for mode 7, where L is the number of cycles `bus_ready` is held low per fetch. While `bus_req` waits for `bus_ready`, it stays high and `bus_addr` stays stable.
- R11: After reset, `done`, `bus_req`, `rf_wr_en`, `flag_suppress` and `ea_is_reg` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin resolving a specifier (sampled when idle) |
| mode | input | 3 | Addressing mode 0..7 |
| dst_reg | input | 3 | Register index of the specifier |
| byte_op | input | 1 | 1 for a byte-sized operation |
| rf_rd_idx | output | 3 | Register file read index |
| rf_rd_data | input | 16 | Register file read data (combinational) |
| rf_wr_en | output | 1 | Register file write strobe |
| rf_wr_idx | output | 3 | Register file write index |
| rf_wr_data | output | 16 | Register file write data |
| bus_req | output | 1 | Word read request |
| bus_addr | output | 16 | Read address |
| bus_ready | input | 1 | Read completes this cycle |
| bus_rdata | input | 16 | Read data, valid with `bus_ready` |
| done | output | 1 | Result valid pulse |
| ea_addr | output | 16 | Resolved memory address (0 for register direct) |
| ea_is_reg | output | 1 | Destination is a register |
| ea_reg | output | 3 | Register index of the result |
| flag_suppress | output | 1 | Memory destination is the status word address |

## Verification
The bench covers the following corner cases:
- Byte-sized steps on registers 6 and 7. A design that honoured the size there would misalign the stack pointer or program counter by one.
- An index sum that wraps past 16'hFFFF, and a PC-relative index through register 7. A design that summed with the stale program counter would land two bytes low.
- A register holding 16'hFFFE in register-direct mode. A design that compared without checking the mode would wrongly suppress flags.
- Pointer fetches under bus stalls, with exact latency counts. A design that advanced before `bus_ready` would latch garbage or finish early.

// File: rtl/dst_ea_pkg.sv
package dst_ea_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_CALC = 3'd1,
      ST_IDX  = 3'd2,
      ST_SUM  = 3'd3,
      ST_PTR  = 3'd4,
      ST_DONE = 3'd5
   } ea_state_t;

   localparam logic [2:0] M_REG    = 3'd0;
   localparam logic [2:0] M_DEF    = 3'd1;
   localparam logic [2:0] M_INC    = 3'd2;
   localparam logic [2:0] M_INCDEF = 3'd3;
   localparam logic [2:0] M_DEC    = 3'd4;
   localparam logic [2:0] M_DECDEF = 3'd5;
   localparam logic [2:0] M_IDX    = 3'd6;
   localparam logic [2:0] M_IDXDEF = 3'd7;

endpackage

// File: rtl/dst_ea_step.sv
// Step size for the auto-increment and auto-decrement modes.
module dst_ea_step #(
   parameter int unsigned DW         = 16,
   parameter int unsigned RW         = 3,
   parameter int unsigned NREG       = 8,
   parameter int unsigned WORD_STEP  = 2,
   parameter int unsigned BYTE_STEP  = 1,
   parameter bit          STACK_WORD = 1'b1
) (
   input  logic          byte_op,
   input  logic [RW-1:0] reg_idx,
   output logic [DW-1:0] step
);

   localparam logic [DW-1:0] W_STEP = DW'(WORD_STEP);
   localparam logic [DW-1:0] B_STEP = DW'(BYTE_STEP);
   localparam logic [RW-1:0] SP_IDX = RW'(NREG - 2);

   logic wide;

   generate
      if (STACK_WORD) begin : g_stack_word
         // the two top registers always keep word alignment
         assign wide = !byte_op || (reg_idx >= SP_IDX);
      end else begin : g_size_only
         logic unused_reg_idx;
         assign unused_reg_idx = ^reg_idx;
         assign wide = !byte_op;
      end
   endgenerate

   assign step = wide ? W_STEP : B_STEP;

endmodule

// File: rtl/dst_ea_psw_cmp.sv
// Detects a memory destination that hits the status word address.
module dst_ea_psw_cmp #(
   parameter int unsigned    DW       = 16,
   parameter logic [DW-1:0]  PSW_ADDR = 16'o177776,
   parameter bit             EN       = 1'b1
) (
   input  logic [DW-1:0] addr,
   input  logic          is_reg,
   output logic          hit
);

   generate
      if (EN) begin : g_cmp
         assign hit = !is_reg && (addr == PSW_ADDR);
      end else begin : g_off
         logic unused_in;
         assign unused_in = ^{addr, is_reg};
         assign hit = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dst_ea_gen.sv
module dst_ea_gen
   import dst_ea_pkg::*;
#(
   parameter int unsigned   DW          = 16,
   parameter int unsigned   NREG        = 8,
   parameter int unsigned   WORD_STEP   = 2,
   parameter int unsigned   BYTE_STEP   = 1,
   parameter bit            STACK_WORD  = 1'b1,
   parameter bit            SUPPRESS_EN = 1'b1,
   parameter logic [DW-1:0] PSW_ADDR    = 16'o177776
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [2:0]               mode,
   input  logic [$clog2(NREG)-1:0]  dst_reg,
   input  logic                     byte_op,
   output logic [$clog2(NREG)-1:0]  rf_rd_idx,
   input  logic [DW-1:0]            rf_rd_data,
   output logic                     rf_wr_en,
   output logic [$clog2(NREG)-1:0]  rf_wr_idx,
   output logic [DW-1:0]            rf_wr_data,
   output logic                     bus_req,
   output logic [DW-1:0]            bus_addr,
   input  logic                     bus_ready,
   input  logic [DW-1:0]            bus_rdata,
   output logic                     done,
   output logic [DW-1:0]            ea_addr,
   output logic                     ea_is_reg,
   output logic [$clog2(NREG)-1:0]  ea_reg,
   output logic                     flag_suppress
);

   localparam int unsigned   RW     = $clog2(NREG);
   localparam logic [RW-1:0] PC_IDX = RW'(NREG - 1);
   localparam logic [DW-1:0] FIX_ST = DW'(WORD_STEP);

   // elaboration-time parameter checks
   generate
      if (DW < 8) begin : g_bad_dw
         $error("dst_ea_gen: DW must be at least 8");
      end
      if (NREG < 4 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
         $error("dst_ea_gen: NREG must be a power of two, at least 4");
      end
      if (BYTE_STEP == 0 || BYTE_STEP > WORD_STEP) begin : g_bad_step
         $error("dst_ea_gen: need 0 < BYTE_STEP <= WORD_STEP");
      end
   endgenerate

   ea_state_t     st_q, st_d;
   logic [2:0]    mode_q;
   logic [RW-1:0] reg_q;
   logic          byte_q;
   logic [DW-1:0] ptr_q;
   logic [DW-1:0] idx_q;

   logic [DW-1:0] var_step;
   logic [DW-1:0] step_amt;
   logic [DW-1:0] upd_val;
   logic [DW-1:0] sum_val;
   logic          is_dec;

   logic          load_res;
   logic [DW-1:0] nxt_addr;
   logic          nxt_is_reg;
   logic          psw_hit;

   dst_ea_step #(
      .DW(DW), .RW(RW), .NREG(NREG),
      .WORD_STEP(WORD_STEP), .BYTE_STEP(BYTE_STEP), .STACK_WORD(STACK_WORD)
   ) u_step (
      .byte_op (byte_q),
      .reg_idx (reg_q),
      .step    (var_step)
   );

   dst_ea_psw_cmp #(
      .DW(DW), .PSW_ADDR(PSW_ADDR), .EN(SUPPRESS_EN)
   ) u_psw (
      .addr   (nxt_addr),
      .is_reg (nxt_is_reg),
      .hit    (psw_hit)
   );

   // register file read index: PC for the index fetch, else the specifier
   always_comb begin
      rf_rd_idx = reg_q;
      if (st_q == ST_CALC && (mode_q == M_IDX || mode_q == M_IDXDEF))
         rf_rd_idx = PC_IDX;
   end

   // register update arithmetic
   always_comb begin
      is_dec   = (mode_q == M_DEC) || (mode_q == M_DECDEF);
      step_amt = ((mode_q == M_INC) || (mode_q == M_DEC)) ? var_step : FIX_ST;
      upd_val  = is_dec ? (rf_rd_data - step_amt) : (rf_rd_data + step_amt);
      sum_val  = rf_rd_data + idx_q;
   end

   assign rf_wr_en   = (st_q == ST_CALC) && (mode_q != M_REG) && (mode_q != M_DEF);
   assign rf_wr_idx  = rf_rd_idx;
   assign rf_wr_data = upd_val;

   assign bus_req  = (st_q == ST_IDX) || (st_q == ST_PTR);
   assign bus_addr = ptr_q;
   assign done     = (st_q == ST_DONE);

   // result selection and next state
   always_comb begin
      st_d       = st_q;
      load_res   = 1'b0;
      nxt_addr   = '0;
      nxt_is_reg = 1'b0;
      unique case (st_q)
         ST_IDLE: if (start) st_d = ST_CALC;
         ST_CALC: begin
            unique case (mode_q)
               M_REG: begin
                  load_res   = 1'b1;
                  nxt_is_reg = 1'b1;
                  st_d       = ST_DONE;
               end
               M_DEF, M_INC: begin
                  load_res = 1'b1;
                  nxt_addr = rf_rd_data;
                  st_d     = ST_DONE;
               end
               M_DEC: begin
                  load_res = 1'b1;
                  nxt_addr = upd_val;
                  st_d     = ST_DONE;
               end
               M_INCDEF, M_DECDEF: st_d = ST_PTR;
               default:            st_d = ST_IDX;
            endcase
         end
         ST_IDX: if (bus_ready) st_d = ST_SUM;
         ST_SUM: begin
            if (mode_q == M_IDX) begin
               load_res = 1'b1;
               nxt_addr = sum_val;
               st_d     = ST_DONE;
            end else begin
               st_d = ST_PTR;
            end
         end
         ST_PTR: begin
            if (bus_ready) begin
               load_res = 1'b1;
               nxt_addr = bus_rdata;
               st_d     = ST_DONE;
            end
         end
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   // operand capture and fetch pointers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= M_REG;
         reg_q  <= '0;
         byte_q <= 1'b0;
         ptr_q  <= '0;
         idx_q  <= '0;
      end else begin
         if (st_q == ST_IDLE && start) begin
            mode_q <= mode;
            reg_q  <= dst_reg;
            byte_q <= byte_op;
         end
         if (st_q == ST_CALC) begin
            ptr_q <= (mode_q == M_DECDEF) ? upd_val : rf_rd_data;
         end
         if (st_q == ST_SUM) begin
            ptr_q <= sum_val;
         end
         if (st_q == ST_IDX && bus_ready) begin
            idx_q <= bus_rdata;
         end
      end
   end

   // held result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_addr       <= '0;
         ea_is_reg     <= 1'b0;
         ea_reg        <= '0;
         flag_suppress <= 1'b0;
      end else if (load_res) begin
         ea_addr       <= nxt_addr;
         ea_is_reg     <= nxt_is_reg;
         ea_reg        <= reg_q;
         flag_suppress <= psw_hit;
      end
   end

endmodule

// File: rtl/dst_ea_gen_chk.sv
module dst_ea_gen_chk #(
   parameter int unsigned   DW       = 16,
   parameter int unsigned   RW       = 3,
   parameter logic [DW-1:0] PSW_ADDR = 16'o177776
) (
   input logic          clk,
   input logic          rst_n,
   input logic          done,
   input logic          bus_req,
   input logic          bus_ready,
   input logic [DW-1:0] bus_addr,
   input logic          rf_wr_en,
   input logic [DW-1:0] ea_addr,
   input logic          ea_is_reg,
   input logic [RW-1:0] ea_reg,
   input logic          flag_suppress
);

   logic unused_reg;
   assign unused_reg = ^ea_reg;

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr)));

   // R9
   reg_no_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ea_is_reg) |-> !flag_suppress);

   // R9
   sup_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && flag_suppress) |-> (ea_addr == PSW_ADDR));

   // R1
   reg_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ea_is_reg) |-> (ea_addr == '0));

   // R10
   wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en |-> (!bus_req && !done));

endmodule

bind dst_ea_gen dst_ea_gen_chk #(
   .DW(DW), .RW(RW), .PSW_ADDR(PSW_ADDR)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .done          (done),
   .bus_req       (bus_req),
   .bus_ready     (bus_ready),
   .bus_addr      (bus_addr),
   .rf_wr_en      (rf_wr_en),
   .ea_addr       (ea_addr),
   .ea_is_reg     (ea_is_reg),
   .ea_reg        (ea_reg),
   .flag_suppress (flag_suppress)
);

// File: tb/dst_ea_gen_bench.sv
`timescale 1ns/1ps
module dst_ea_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = 3'd0;
   logic [2:0]  dst_reg = 3'd0;
   logic        byte_op = 1'b0;
   logic [2:0]  rf_rd_idx;
   logic [15:0] rf_rd_data;
   logic        rf_wr_en;
   logic [2:0]  rf_wr_idx;
   logic [15:0] rf_wr_data;
   logic        bus_req;
   logic [15:0] bus_addr;
   logic        bus_ready;
   logic [15:0] bus_rdata;
   logic        done;
   logic [15:0] ea_addr;
   logic        ea_is_reg;
   logic [2:0]  ea_reg;
   logic        flag_suppress;

   always #2 clk = ~clk;

   dst_ea_gen u_dst_ea_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .dst_reg(dst_reg),
      .byte_op(byte_op), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
      .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_ready(bus_ready),
      .bus_rdata(bus_rdata), .done(done), .ea_addr(ea_addr),
      .ea_is_reg(ea_is_reg), .ea_reg(ea_reg), .flag_suppress(flag_suppress)
   );

   // register file model with a preload port
   logic [15:0] rf [0:7];
   logic        pl_en = 1'b0;
   logic [2:0]  pl_idx = 3'd0;
   logic [15:0] pl_val = 16'h0;

   always @(posedge clk) begin
      if (pl_en)         rf[pl_idx]    <= pl_val;
      else if (rf_wr_en) rf[rf_wr_idx] <= rf_wr_data;
   end
   assign rf_rd_data = rf[rf_rd_idx];

   // memory and stalling bus model
   logic [15:0] mem [0:1023];
   int          lat_cfg = 0;
   int          wcnt = 0;
   always @(posedge clk) begin
      if (!bus_req || bus_ready) wcnt <= 0;
      else                       wcnt <= wcnt + 1;
   end
   assign bus_ready = bus_req && (wcnt == lat_cfg);
   assign bus_rdata = mem[bus_addr[10:1]];

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   typedef struct packed {
      logic [2:0]  md;
      logic [2:0]  rg;
      logic        byt;
      logic [15:0] rv;
      logic [15:0] pc;
      logic [15:0] ea;
      logic        isreg;
      logic        sup;
      logic [15:0] erv;
      logic [15:0] epc;
   } vec_t;

   localparam int NV = 22;
   // md rg byt rv pc | ea isreg sup erv epc
   localparam logic [88:0] VEC [NV] = '{
      {3'd0,3'd3,1'b0,16'h0100,16'h0200, 16'h0000,1'b1,1'b0,16'h0100,16'h0200},
      {3'd0,3'd2,1'b0,16'hFFFE,16'h0200, 16'h0000,1'b1,1'b0,16'hFFFE,16'h0200},
      {3'd1,3'd2,1'b0,16'hFFFE,16'h0200, 16'hFFFE,1'b0,1'b1,16'hFFFE,16'h0200},
      {3'd1,3'd2,1'b1,16'h0100,16'h0200, 16'h0100,1'b0,1'b0,16'h0100,16'h0200},
      {3'd2,3'd1,1'b0,16'h0100,16'h0200, 16'h0100,1'b0,1'b0,16'h0102,16'h0200},
      {3'd2,3'd1,1'b1,16'h0100,16'h0200, 16'h0100,1'b0,1'b0,16'h0101,16'h0200},
      {3'd2,3'd6,1'b1,16'h0100,16'h0200, 16'h0100,1'b0,1'b0,16'h0102,16'h0200},
      {3'd2,3'd7,1'b1,16'h0200,16'h0200, 16'h0200,1'b0,1'b0,16'h0202,16'h0202},
      {3'd3,3'd4,1'b0,16'h0100,16'h0200, 16'hFFFE,1'b0,1'b1,16'h0102,16'h0200},
      {3'd3,3'd1,1'b1,16'h0102,16'h0200, 16'h1234,1'b0,1'b0,16'h0104,16'h0200},
      {3'd4,3'd5,1'b1,16'h0104,16'h0200, 16'h0103,1'b0,1'b0,16'h0103,16'h0200},
      {3'd4,3'd5,1'b0,16'h0104,16'h0200, 16'h0102,1'b0,1'b0,16'h0102,16'h0200},
      {3'd4,3'd6,1'b1,16'h0104,16'h0200, 16'h0102,1'b0,1'b0,16'h0102,16'h0200},
      {3'd5,3'd0,1'b0,16'h0104,16'h0200, 16'h1234,1'b0,1'b0,16'h0102,16'h0200},
      {3'd5,3'd0,1'b1,16'h0102,16'h0200, 16'hFFFE,1'b0,1'b1,16'h0100,16'h0200},
      {3'd6,3'd2,1'b0,16'h0100,16'h0200, 16'h0110,1'b0,1'b0,16'h0100,16'h0202},
      {3'd6,3'd2,1'b0,16'h0100,16'h0202, 16'h00F0,1'b0,1'b0,16'h0100,16'h0204},
      {3'd6,3'd2,1'b0,16'h000E,16'h0204, 16'hFFFE,1'b0,1'b1,16'h000E,16'h0206},
      {3'd7,3'd3,1'b0,16'h0300,16'h0200, 16'hFFFE,1'b0,1'b1,16'h0300,16'h0202},
      {3'd7,3'd3,1'b1,16'h0300,16'h0202, 16'h4444,1'b0,1'b0,16'h0300,16'h0204},
      {3'd6,3'd7,1'b0,16'h0200,16'h0200, 16'h0212,1'b0,1'b0,16'h0202,16'h0202},
      {3'd4,3'd7,1'b1,16'h0204,16'h0204, 16'h0202,1'b0,1'b0,16'h0202,16'h0202}
   };

   function automatic string mode_req(input logic [2:0] m);
      case (m)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         3'd5: return "R6";
         3'd6: return "R7";
         default: return "R8";
      endcase
   endfunction

   // R10: expected edges from start sample to done
   function automatic int exp_lat(input logic [2:0] m, input int lat);
      case (m)
         3'd3, 3'd5: return 3 + lat;
         3'd6:       return 4 + lat;
         3'd7:       return 5 + 2 * lat;
         default:    return 2;
      endcase
   endfunction

   task automatic preload(input logic [2:0] idx, input logic [15:0] val);
      @(negedge clk);
      pl_en = 1'b1; pl_idx = idx; pl_val = val;
      @(negedge clk);
      pl_en = 1'b0;
   endtask

   task automatic run_op(input logic [2:0] m, input logic [2:0] r, input logic b,
                         output int cyc);
      @(negedge clk);
      start = 1'b1; mode = m; dst_reg = r; byte_op = b;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic run_vec(input int i, input int lat);
      vec_t v;
      int   cyc;
      string rq;
      v = vec_t'(VEC[i]);
      rq = mode_req(v.md);
      lat_cfg = lat;
      for (int k = 0; k < 8; k++) preload(3'(k), 16'h0AA0 + 16'(k));
      preload(v.rg, v.rv);
      if (v.rg != 3'd7) preload(3'd7, v.pc);
      run_op(v.md, v.rg, v.byt, cyc);
      chk(ea_addr == v.ea, rq, ea_addr, v.ea);
      chk(ea_is_reg == v.isreg, rq, ea_is_reg, v.isreg);
      chk(ea_reg == v.rg, rq, ea_reg, v.rg);
      chk(rf[v.rg] == v.erv, rq, rf[v.rg], v.erv);
      chk(rf[7] == v.epc, rq, rf[7], v.epc);
      chk(flag_suppress == v.sup, "R9", flag_suppress, v.sup);
      chk(cyc == exp_lat(v.md, lat), "R10", cyc, exp_lat(v.md, lat));
   endtask

   initial begin
      int cyc;
      logic [15:0] held;
      for (int a = 0; a < 1024; a++) mem[a] = 16'h0;
      mem[16'h0100 >> 1] = 16'hFFFE;
      mem[16'h0102 >> 1] = 16'h1234;
      mem[16'h0200 >> 1] = 16'h0010;
      mem[16'h0202 >> 1] = 16'hFFF0;
      mem[16'h0204 >> 1] = 16'hFFF0;
      mem[16'h0310 >> 1] = 16'hFFFE;
      mem[16'h02F0 >> 1] = 16'h4444;
      for (int k = 0; k < 8; k++) rf[k] = 16'h0;

      repeat (3) @(negedge clk);
      // R11: reset state
      chk(done == 1'b0, "R11", done, 0);
      chk(bus_req == 1'b0, "R11", bus_req, 0);
      chk(rf_wr_en == 1'b0, "R11", rf_wr_en, 0);
      chk(flag_suppress == 1'b0, "R11", flag_suppress, 0);
      chk(ea_is_reg == 1'b0, "R11", ea_is_reg, 0);
      rst_n = 1'b1;

      // table walk, no stall then with stalls
      for (int i = 0; i < NV; i++) run_vec(i, 0);
      for (int i = 0; i < NV; i++) run_vec(i, 3);

      // R10: done is a single pulse and the result is held afterwards
      lat_cfg = 1;
      preload(3'd4, 16'h0100);
      run_op(3'd3, 3'd4, 1'b0, cyc);
      held = ea_addr;
      @(negedge clk);
      chk(done == 1'b0, "R10", done, 0);
      chk(ea_addr == held, "R10", ea_addr, held);
      chk(flag_suppress == 1'b1, "R9", flag_suppress, 1);

      // R1: register direct after a suppressed memory result clears suppress
      preload(3'd5, 16'hFFFE);
      run_op(3'd0, 3'd5, 1'b1, cyc);
      chk(ea_is_reg == 1'b1, "R1", ea_is_reg, 1);
      chk(flag_suppress == 1'b0, "R9", flag_suppress, 0);
      chk(rf[5] == 16'hFFFE, "R1", rf[5], 16'hFFFE);

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL R10 watchdog actual=%0h expected=%0h", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule